// File: doc/BRIEF.md
# Two-Source Ordered Merge Queue

This block collects 8-bit words from two independent producers and hands them to one consumer in the order they were accepted. A producer presents a word together with a strobe, and the queue takes the word at the clock edge of that cycle. The producer does not wait for an acknowledgement. An input selector funnels whichever producer is active into a single eight-entry circular store.

The consumer side uses a valid/ready handshake. The word at the head of the queue is shown whenever the queue holds data. It is removed at an edge where ready is high.

The producers are expected never to strobe in the same cycle. If they do, source A wins and source B's word is lost, and a sticky collision flag records the event. A word offered while the queue is full is discarded, and a sticky overflow flag records that loss. Both flags are cleared only by reset.

Top module: `merge_fifo`

## Requirements
- R1: While rst_ni is low and after its release, empty_o is 1, full_o is 0, out_vld_o is 0, and overflow_o and collision_o are 0.
- R2: A word strobed into an empty queue at a rising edge appears on out_data_o with out_vld_o high right after that edge.
- R3: Words leave on out_data_o in exactly the order they were accepted, whichever source supplied each one.
- R4: After eight accepted words with no removal, full_o is 1 and empty_o is 0. The occupancy never exceeds eight, and full_o and empty_o are never both 1.
- R5: A strobe while full_o is 1 stores nothing, including in a cycle that also removes a word. The same strobe sets overflow_o, which stays 1 until reset.
- R6: Ready while the queue is empty removes nothing. out_vld_o stays 0, and the next accepted word is still the next word delivered.
- R7: If both strobes are high in one cycle, only a_data_i is queued and collision_o becomes 1 and stays 1 until reset.
- R8: In a cycle with both an accepted write and a removal, the occupancy is unchanged and ordering is kept.
- R9: out_vld_o is always the inverse of empty_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_vld_i | input | 1 | Source A strobe |
| a_data_i | input | 8 | Source A word |
| b_vld_i | input | 1 | Source B strobe |
| b_data_i | input | 8 | Source B word |
| out_vld_o | output | 1 | Head word present |
| out_data_o | output | 8 | Head word |
| out_rdy_i | input | 1 | Consumer takes head word at this edge |
| full_o | output | 1 | Eight words held |
| empty_o | output | 1 | No words held |
| overflow_o | output | 1 | Sticky: a word was dropped while full |
| collision_o | output | 1 | Sticky: both sources strobed together |

## Verification
Every result is due one edge after its stimulus. A strobe or a removal at one rising edge is visible on the outputs, flags included, right after that edge. The bench drives inputs on the falling edge and compares all outputs against a queue model just before the following rising edge. Each comparison therefore sees the effect of exactly the previous edge. The sweep covers alternating and single-source fills to full, pushes beyond full, removal from empty, collisions, and concurrent push and pop at several occupancies.

// File: rtl/merge_fifo_pkg.sv
package merge_fifo_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } src_e;
endpackage

// File: rtl/merge_fifo_sel.sv
module merge_fifo_sel
  import merge_fifo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_vld_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              b_vld_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              collision_o
);
  src_e src;
  logic coll_q;

  // source A has priority on a clash
  always_comb begin
    if (a_vld_i)      src = SRC_A;
    else if (b_vld_i) src = SRC_B;
    else              src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_A:   wr_data_o = a_data_i;
      SRC_B:   wr_data_o = b_data_i;
      default: wr_data_o = '0;
    endcase
  end

  assign wr_req_o = (src != SRC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  coll_q <= 1'b0;
    else if (a_vld_i && b_vld_i)  coll_q <= 1'b1;
  end

  assign collision_o = coll_q;

  AST_COLL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_vld_i && b_vld_i) |=> collision_o); // R7
  AST_COLL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |=> collision_o); // R7
endmodule

// File: rtl/merge_fifo_ctrl.sv
module merge_fifo_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic             rd_req_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             overflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             rd_en;

  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);
  assign wr_en_o = wr_req_i && !full_o;
  assign rd_en   = rd_req_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_en_o) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_en)   rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      if (wr_en_o && !rd_en)      cnt_q <= cnt_q + 1'b1;
      else if (rd_en && !wr_en_o) cnt_q <= cnt_q - 1'b1;
      if (wr_req_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign wr_ptr_o   = wr_ptr_q;
  assign rd_ptr_o   = rd_ptr_q;
  assign overflow_o = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R4
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R4
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_req_i) |=> (overflow_o && $stable(wr_ptr_q))); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R5
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !wr_req_i) |=> (empty_o && $stable(rd_ptr_q))); // R6
  AST_RW_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && rd_req_i && !full_o && !empty_o) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/merge_fifo_store.sv
module merge_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_ptr_i == PTR_W'(g))) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_ptr_i];
endmodule

// File: rtl/merge_fifo.sv
module merge_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_vld_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              b_vld_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_rdy_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic              collision_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic              wr_req, wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  merge_fifo_sel #(.DATA_W(DATA_W)) i_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_vld_i     (a_vld_i),
    .a_data_i    (a_data_i),
    .b_vld_i     (b_vld_i),
    .b_data_i    (b_data_i),
    .wr_req_o    (wr_req),
    .wr_data_o   (wr_data),
    .collision_o (collision_o)
  );

  merge_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (wr_req),
    .rd_req_i   (out_rdy_i),
    .wr_en_o    (wr_en),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .overflow_o (overflow_o)
  );

  merge_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (wr_data),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (out_data_o)
  );

  assign out_vld_o = !empty_o;

  AST_VLD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o != empty_o); // R9
  AST_FIRST_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && (a_vld_i || b_vld_i)) |=> out_vld_o); // R2
endmodule

// File: tb/test_merge_fifo.sv
module test_merge_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       a_vld = 1'b0, b_vld = 1'b0, rdy = 1'b0;
  logic [7:0] a_data = '0, b_data = '0;
  logic       out_vld, full, empty, ovf, coll;
  logic [7:0] out_data;

  int checks = 0, errors = 0, cycles = 0;
  int mq[DEPTH];
  int mhead = 0, mcnt = 0;
  bit movf = 0, mcol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  merge_fifo i_merge_fifo (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_vld_i(a_vld), .a_data_i(a_data),
    .b_vld_i(b_vld), .b_data_i(b_data),
    .out_vld_o(out_vld), .out_data_o(out_data), .out_rdy_i(rdy),
    .full_o(full), .empty_o(empty), .overflow_o(ovf), .collision_o(coll)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs against the model, just before the next rising edge
  task automatic observe(string dtag);
    chk("R9", out_vld, mcnt != 0);
    chk("R6", empty, mcnt == 0);
    chk("R4", full, mcnt == DEPTH);
    chk("R5", ovf, movf);
    chk("R7", coll, mcol);
    if (mcnt != 0) chk(dtag, out_data, mq[mhead]);
  endtask

  // drive one cycle at the falling edge; the model follows the rising edge
  task automatic step(bit av, int ad, bit bv, int bd, bit rd, string dtag);
    bit wr, pop;
    int wd;
    @(negedge clk);
    a_vld = av; a_data = 8'(ad); b_vld = bv; b_data = 8'(bd); rdy = rd;
    #1;
    observe(dtag);
    wr  = av || bv;
    wd  = av ? (ad & 255) : (bd & 255);
    pop = rd && (mcnt != 0);
    if (av && bv) mcol = 1;
    if (wr && mcnt == DEPTH) movf = 1;
    if (pop) begin mhead = (mhead + 1) % DEPTH; mcnt--; end
    if (wr && (mcnt + (pop ? 1 : 0)) < DEPTH) begin
      mq[(mhead + mcnt) % DEPTH] = wd;
      mcnt++;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, "R3");
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    // R1: outputs while held in reset and right after release
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", empty, 1); chk("R1", full, 0); chk("R1", out_vld, 0);
    chk("R1", ovf, 0);   chk("R1", coll, 0);
    rst_ni = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", empty, 1); chk("R1", out_vld, 0);

    // R2: a single word is visible one edge after its strobe
    step(0, 0, 1, 8'h5A, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    chk("R2", out_data, 8'h5A);
    step(0, 0, 0, 0, 1, "R2");
    idle();

    // R6: removal from an empty queue changes nothing
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R6");
    step(1, 8'h33, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, "R6");
    idle();

    // R3/R4/R5: for each source pattern, fill past full, then drain
    for (int pat = 0; pat < 3; pat++) begin
      for (int i = 0; i < DEPTH + 2; i++) begin
        bit use_a = (pat == 0) ? 1 : (pat == 1) ? 0 : ((i % 2) == 0);
        step(use_a, 16 * pat + i, !use_a, 100 + 16 * pat + i, 0, "R3");
      end
      chk("R4", full, 1);
      chk("R5", ovf, 1);
      // push while full and popping: word must still be dropped
      step(1, 8'hEE, 0, 0, 1, "R5");
      for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 1, "R3");
      idle();
    end

    // R8: concurrent push and pop at several occupancies
    for (int occ = 1; occ < DEPTH; occ++) begin
      for (int i = 0; i < occ; i++) step(0, 0, 1, 200 + i, 0, "R8");
      for (int i = 0; i < 5; i++) step(i % 2 == 0, 40 + i, i % 2 != 0, 60 + i, 1, "R8");
      chk("R8", full, 0); chk("R8", empty, 0);
      for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, "R8");
    end

    // R7: clash between sources keeps only source A's word
    step(1, 8'h11, 1, 8'h22, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    chk("R7", out_data, 8'h11);
    step(0, 0, 1, 8'h23, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    for (int i = 0; i < 3; i++) idle();
    chk("R7", coll, 1);

    finish_run();
  end
endmodule